// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state changes a small 32-bit processor makes when it takes an exception. The pipeline presents one request per cycle. Each request carries a 3-bit class, a 5-bit cause code, the PC of the faulting instruction and the faulting data address. In a single clock edge the block updates its control registers:

- the status word
- the saved status for exceptions and the saved status for breaks
- the exception-cause register
- the TLB side flags
- the two return-address registers
- the fault-address register
- the program counter

It raises a one-cycle completion pulse in the following cycle.

Whether an exception nests is decided by the exception-handling bit of the status word. A TLB miss taken while that bit is clear is a fast miss and goes to a dedicated vector. A miss taken while the bit is set is a double miss: it goes to the general vector and leaves the saved status and return address untouched. Supervisor violations, traps and breaks also preserve the saved state when they nest. Breaks use their own saved-status and return-address pair. The two vectors and the reset PC are parameters.

The request port has no back-pressure. The block accepts a request in any cycle that is not in reset and commits it on that edge, so the requester never waits. A request with the reserved class is refused: it changes no state and pulses the error output instead of the completion output. Reset is synchronous and active high.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is high at a clock edge, every control register is cleared, the PC is loaded with RESET_PC, and the completion and error outputs are low.
- R2: Class 0 (interrupt) copies status into the saved status and sets status bit 3 (interrupt-handler). It clears status bit 0 (interrupt enable) and bit 1 (user mode), sets the return address to PC+4 and loads the PC with GEN_VEC.
- R3: Every accepted class other than 6 writes the cause code into bits [6:2] of the cause register. The other bits of that register keep their values.
- R4: Class 1 (TLB miss) with status bit 2 (exception-handling) clear saves status and sets bit 2. It clears bits 0 and 1. It clears TLB flag bit 1 (double miss) and sets TLB flag bit 0 (write). It sets the return address to PC+4 and loads the PC with FAST_VEC.
- R5: Class 1 with status bit 2 set sets TLB flag bit 1, sets status bit 2 and clears bits 0 and 1. It loads the PC with GEN_VEC and leaves the saved status and the return address unchanged.
- R6: Class 3 (supervisor violation) and class 4 (trap or illegal instruction) save status and set the return address to PC+4 only if status bit 2 was clear. In every case they set bit 2, clear bits 0 and 1, and load GEN_VEC.
- R7: Class 5 (break) copies status into the break-saved status and sets the break return address to PC+4 only if status bit 2 was clear. It then sets bit 2, clears bits 0 and 1, and loads GEN_VEC.
- R8: Class 2 (TLB permission) always saves status and sets the return address to PC+4. It sets status bit 2, clears bits 0 and 1, and loads GEN_VEC.
- R9: Class 6 (misaligned access) loads the fault-address register with the faulting address and replaces the whole cause register with the cause code shifted left by two. Status and PC are unchanged.
- R10: For each accepted request, the completion output is high for exactly the one cycle after the request edge, and all register updates are visible in that same cycle. With no request it stays low and no register changes.
- R11: Class 7 is reserved. It raises the error output for one cycle, leaves every register unchanged and does not raise the completion output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Exception request, accepted on the edge where it is high |
| req_class | input | 3 | Exception class, 0..7 as listed in the requirements |
| req_cause | input | 5 | Cause code for the cause register |
| cur_pc | input | 32 | PC of the excepting instruction |
| fault_addr | input | 32 | Faulting data address |
| status_o | output | 32 | Status word |
| estatus_o | output | 32 | Saved status for exceptions |
| bstatus_o | output | 32 | Saved status for breaks |
| cause_o | output | 32 | Exception-cause register |
| tlbflags_o | output | 32 | TLB side flags (bit 0 write, bit 1 double miss) |
| eret_o | output | 32 | Exception return address |
| bret_o | output | 32 | Break return address |
| badaddr_o | output | 32 | Fault-address register |
| pc_o | output | 32 | Program counter |
| done_o | output | 1 | Completion pulse, one cycle after an accepted request |
| err_o | output | 1 | Error pulse, one cycle after a reserved-class request |

## Verification
Each register update and the completion or error pulse are due in the cycle that follows the edge on which the request was sampled. Nothing takes longer, so every result has a latency of exactly one cycle. The bench drives a request on a falling edge and drops it on the next falling edge, and it compares every output against its model at that point. On idle cycles it compares again to show that the pulses have dropped and no register has moved. Random sequences of classes cover all the nesting combinations, with resets at random points. Directed sequences cover fast miss then double miss, nested traps and breaks, and the reserved class.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EXC_IRQ      = 3'd0,
    EXC_TLB_MISS = 3'd1,
    EXC_TLB_PERM = 3'd2,
    EXC_SUPER    = 3'd3,
    EXC_TRAP     = 3'd4,
    EXC_BREAK    = 3'd5,
    EXC_UNALIGN  = 3'd6,
    EXC_RSVD     = 3'd7
  } exc_class_e;

  // status word bit positions
  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;

  // TLB flag bit positions
  localparam int TF_WR  = 0;
  localparam int TF_DBL = 1;

  localparam int CAUSE_W   = 5;
  localparam int CAUSE_LSB = 2;

  typedef enum logic [1:0] {
    VEC_KEEP = 2'd0,
    VEC_GEN  = 2'd1,
    VEC_FAST = 2'd2
  } vec_sel_e;

  typedef struct packed {
    logic     take;        // accepted request
    logic     bad;         // reserved class
    logic     save_es;
    logic     save_bs;
    logic     set_eret;
    logic     set_bret;
    logic     set_eh;
    logic     set_ih;
    logic     mask_st;     // clear interrupt enable and user mode
    logic     put_cause;   // field write
    logic     whole_cause; // full overwrite
    logic     load_bad;
    logic     tf_set_wr;
    logic     tf_clr_dbl;
    logic     tf_set_dbl;
    vec_sel_e vec;
  } exc_act_t;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] cls,
  input  logic       eh,
  output exc_act_t   act
);

  always_comb begin
    act = '0;
    act.vec = VEC_KEEP;
    if (valid) begin
      unique case (exc_class_e'(cls))
        EXC_IRQ: begin
          act.take      = 1'b1;
          act.save_es   = 1'b1;
          act.set_eret  = 1'b1;
          act.set_ih    = 1'b1;
          act.mask_st   = 1'b1;
          act.put_cause = 1'b1;
          act.vec       = VEC_GEN;
        end
        EXC_TLB_MISS: begin
          act.take      = 1'b1;
          act.set_eh    = 1'b1;
          act.mask_st   = 1'b1;
          act.put_cause = 1'b1;
          if (!eh) begin
            act.save_es    = 1'b1;
            act.set_eret   = 1'b1;
            act.tf_clr_dbl = 1'b1;
            act.tf_set_wr  = 1'b1;
            act.vec        = VEC_FAST;
          end else begin
            act.tf_set_dbl = 1'b1;
            act.vec        = VEC_GEN;
          end
        end
        EXC_TLB_PERM: begin
          act.take      = 1'b1;
          act.save_es   = 1'b1;
          act.set_eret  = 1'b1;
          act.set_eh    = 1'b1;
          act.mask_st   = 1'b1;
          act.put_cause = 1'b1;
          act.vec       = VEC_GEN;
        end
        EXC_SUPER, EXC_TRAP: begin
          act.take      = 1'b1;
          act.save_es   = !eh;
          act.set_eret  = !eh;
          act.set_eh    = 1'b1;
          act.mask_st   = 1'b1;
          act.put_cause = 1'b1;
          act.vec       = VEC_GEN;
        end
        EXC_BREAK: begin
          act.take      = 1'b1;
          act.save_bs   = !eh;
          act.set_bret  = !eh;
          act.set_eh    = 1'b1;
          act.mask_st   = 1'b1;
          act.put_cause = 1'b1;
          act.vec       = VEC_GEN;
        end
        EXC_UNALIGN: begin
          act.take        = 1'b1;
          act.load_bad    = 1'b1;
          act.whole_cause = 1'b1;
        end
        default: begin
          act.bad = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [DATA_W-1:0] RESET_PC   = '0,
  parameter logic [DATA_W-1:0] GEN_VEC    = '0,
  parameter logic [DATA_W-1:0] FAST_VEC   = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  exc_act_t            act,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic [DATA_W-1:0]   cur_pc,
  input  logic [DATA_W-1:0]   fault_addr,
  output logic [DATA_W-1:0]   status_q,
  output logic [DATA_W-1:0]   estatus_q,
  output logic [DATA_W-1:0]   bstatus_q,
  output logic [DATA_W-1:0]   cause_q,
  output logic [DATA_W-1:0]   tflags_q,
  output logic [DATA_W-1:0]   eret_q,
  output logic [DATA_W-1:0]   bret_q,
  output logic [DATA_W-1:0]   bad_q,
  output logic [DATA_W-1:0]   pc_q,
  output logic                done_q,
  output logic                err_q
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);
  localparam int                CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;

  logic [DATA_W-1:0] status_nx, cause_nx, tflags_nx, pc_nx, ret_addr;

  assign ret_addr = cur_pc + STEP;

  always_comb begin
    status_nx = status_q;
    if (act.set_eh) status_nx[ST_EH] = 1'b1;
    if (act.set_ih) status_nx[ST_IH] = 1'b1;
    if (act.mask_st) begin
      status_nx[ST_PIE] = 1'b0;
      status_nx[ST_U]   = 1'b0;
    end
  end

  always_comb begin
    cause_nx = cause_q;
    if (act.whole_cause) begin
      cause_nx = '0;
      cause_nx[CAUSE_MSB:CAUSE_LSB] = cause;
    end else if (act.put_cause) begin
      cause_nx[CAUSE_MSB:CAUSE_LSB] = cause;
    end
  end

  always_comb begin
    tflags_nx = tflags_q;
    if (act.tf_clr_dbl) tflags_nx[TF_DBL] = 1'b0;
    if (act.tf_set_dbl) tflags_nx[TF_DBL] = 1'b1;
    if (act.tf_set_wr)  tflags_nx[TF_WR]  = 1'b1;
  end

  always_comb begin
    unique case (act.vec)
      VEC_GEN:  pc_nx = GEN_VEC;
      VEC_FAST: pc_nx = FAST_VEC;
      default:  pc_nx = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      estatus_q <= '0;
      bstatus_q <= '0;
      cause_q   <= '0;
      tflags_q  <= '0;
      eret_q    <= '0;
      bret_q    <= '0;
      bad_q     <= '0;
      pc_q      <= RESET_PC;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      status_q <= status_nx;
      cause_q  <= cause_nx;
      tflags_q <= tflags_nx;
      pc_q     <= pc_nx;
      if (act.save_es)  estatus_q <= status_q;
      if (act.save_bs)  bstatus_q <= status_q;
      if (act.set_eret) eret_q    <= ret_addr;
      if (act.set_bret) bret_q    <= ret_addr;
      if (act.load_bad) bad_q     <= fault_addr;
      done_q <= act.take;
      err_q  <= act.bad;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [DATA_W-1:0] RESET_PC   = 32'h0000_0400,
  parameter logic [DATA_W-1:0] GEN_VEC    = 32'h1000_0020,
  parameter logic [DATA_W-1:0] FAST_VEC   = 32'h1000_0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         req_class,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [DATA_W-1:0]  cur_pc,
  input  logic [DATA_W-1:0]  fault_addr,
  output logic [DATA_W-1:0]  status_o,
  output logic [DATA_W-1:0]  estatus_o,
  output logic [DATA_W-1:0]  bstatus_o,
  output logic [DATA_W-1:0]  cause_o,
  output logic [DATA_W-1:0]  tlbflags_o,
  output logic [DATA_W-1:0]  eret_o,
  output logic [DATA_W-1:0]  bret_o,
  output logic [DATA_W-1:0]  badaddr_o,
  output logic [DATA_W-1:0]  pc_o,
  output logic               done_o,
  output logic               err_o
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

  exc_act_t act;

  exc_decode u_decode (
    .valid (req_valid),
    .cls   (req_class),
    .eh    (status_o[ST_EH]),
    .act   (act)
  );

  exc_state #(
    .DATA_W     (DATA_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (RESET_PC),
    .GEN_VEC    (GEN_VEC),
    .FAST_VEC   (FAST_VEC)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .cause      (req_cause),
    .cur_pc     (cur_pc),
    .fault_addr (fault_addr),
    .status_q   (status_o),
    .estatus_q  (estatus_o),
    .bstatus_q  (bstatus_o),
    .cause_q    (cause_o),
    .tflags_q   (tlbflags_o),
    .eret_q     (eret_o),
    .bret_q     (bret_o),
    .bad_q      (badaddr_o),
    .pc_q       (pc_o),
    .done_q     (done_o),
    .err_q      (err_o)
  );

  // R2: interrupt entry
  a_r2_irq_entry: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class == EXC_IRQ) |->
      (status_o[ST_IH] && !status_o[ST_PIE] && !status_o[ST_U] &&
       pc_o == GEN_VEC && eret_o == $past(cur_pc) + STEP &&
       estatus_o == $past(status_o)));

  // R4: fast miss
  a_r4_fast_miss: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class == EXC_TLB_MISS && !status_o[ST_EH]) |->
      (pc_o == FAST_VEC && tlbflags_o[TF_WR] && !tlbflags_o[TF_DBL] &&
       estatus_o == $past(status_o) && status_o[ST_EH]));

  // R5: double miss keeps saved state
  a_r5_double_miss: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class == EXC_TLB_MISS && status_o[ST_EH]) |->
      (pc_o == GEN_VEC && tlbflags_o[TF_DBL] &&
       estatus_o == $past(estatus_o) && eret_o == $past(eret_o)));

  // R9: misaligned access
  a_r9_unaligned: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class == EXC_UNALIGN) |->
      (badaddr_o == $past(fault_addr) &&
       cause_o == (DATA_W'($past(req_cause)) << CAUSE_LSB) &&
       pc_o == $past(pc_o) && status_o == $past(status_o)));

  // R10: completion pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class != EXC_RSVD) |-> (done_o && !err_o));

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid && !rst) |-> (!done_o && !err_o && $stable(status_o) && $stable(pc_o)));

  // R11: reserved class refused
  a_r11_reserved: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && !rst && req_class == EXC_RSVD) |->
      (err_o && !done_o && status_o == $past(status_o) && pc_o == $past(pc_o) &&
       cause_o == $past(cause_o)));

endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

  localparam int          W   = 32;
  localparam logic [31:0] RPC = 32'h0000_0400;
  localparam logic [31:0] GV  = 32'h1000_0020;
  localparam logic [31:0] FV  = 32'h1000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_class = '0;
  logic [4:0]  req_cause = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] fault_addr = '0;
  logic [31:0] status_o, estatus_o, bstatus_o, cause_o, tlbflags_o;
  logic [31:0] eret_o, bret_o, badaddr_o, pc_o;
  logic        done_o, err_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_st, m_es, m_bs, m_cs, m_tf, m_er, m_br, m_bad, m_pc;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.DATA_W(W), .INSN_BYTES(4), .RESET_PC(RPC), .GEN_VEC(GV), .FAST_VEC(FV))
  i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_cause(req_cause), .cur_pc(cur_pc), .fault_addr(fault_addr),
    .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
    .cause_o(cause_o), .tlbflags_o(tlbflags_o), .eret_o(eret_o), .bret_o(bret_o),
    .badaddr_o(badaddr_o), .pc_o(pc_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c, input logic eh);
    case (c)
      3'd0: return "R2";
      3'd1: return eh ? "R5" : "R4";
      3'd2: return "R8";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check_regs(input string tag, input string ctag);
    chk(tag, "status", status_o, m_st);
    chk(tag, "estatus", estatus_o, m_es);
    chk(tag, "bstatus", bstatus_o, m_bs);
    chk(ctag, "cause", cause_o, m_cs);
    chk(tag, "tlbflags", tlbflags_o, m_tf);
    chk(tag, "eret", eret_o, m_er);
    chk(tag, "bret", bret_o, m_br);
    chk(tag, "badaddr", badaddr_o, m_bad);
    chk(tag, "pc", pc_o, m_pc);
  endtask

  task automatic model_reset();
    m_st = '0; m_es = '0; m_bs = '0; m_cs = '0; m_tf = '0;
    m_er = '0; m_br = '0; m_bad = '0; m_pc = RPC;
  endtask

  // R1: reset state
  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_regs("R1", "R1");
    chk("R1", "done", 32'(done_o), 32'd0);
    chk("R1", "err", 32'(err_o), 32'd0);
  endtask

  // expected update computed from the requirements
  task automatic model_apply(input logic [2:0] c, input logic [4:0] cz,
                             input logic [31:0] pc, input logic [31:0] fa);
    logic [31:0] old = m_st;
    logic        eh  = old[2];
    logic [31:0] masked = (old | 32'h4) & ~32'h3;
    logic [31:0] newc = (m_cs & ~32'h7C) | (32'(cz) << 2);
    case (c)
      3'd0: begin m_es = old; m_st = (old | 32'h8) & ~32'h3; m_er = pc + 4; m_pc = GV; m_cs = newc; end
      3'd1: begin
        m_cs = newc; m_st = masked;
        if (!eh) begin m_es = old; m_tf = (m_tf & ~32'h2) | 32'h1; m_er = pc + 4; m_pc = FV; end
        else begin m_tf = m_tf | 32'h2; m_pc = GV; end
      end
      3'd2: begin m_es = old; m_er = pc + 4; m_st = masked; m_pc = GV; m_cs = newc; end
      3'd3, 3'd4: begin
        if (!eh) begin m_es = old; m_er = pc + 4; end
        m_st = masked; m_pc = GV; m_cs = newc;
      end
      3'd5: begin
        if (!eh) begin m_bs = old; m_br = pc + 4; end
        m_st = masked; m_pc = GV; m_cs = newc;
      end
      3'd6: begin m_bad = fa; m_cs = 32'(cz) << 2; end
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] c, input logic [4:0] cz,
                       input logic [31:0] pc, input logic [31:0] fa);
    string tag = tag_of(c, m_st[2]);
    string ctag = (c == 3'd6 || c == 3'd7) ? tag : "R3";
    model_apply(c, cz, pc, fa);
    req_valid = 1'b1; req_class = c; req_cause = cz; cur_pc = pc; fault_addr = fa;
    @(negedge clk);
    req_valid = 1'b0;
    check_regs(tag, ctag);
    chk((c == 3'd7) ? "R11" : "R10", "done", 32'(done_o), (c == 3'd7) ? 32'd0 : 32'd1);
    chk((c == 3'd7) ? "R11" : "R10", "err", 32'(err_o), (c == 3'd7) ? 32'd1 : 32'd0);
  endtask

  // R10: idle cycle, pulses drop and nothing moves
  task automatic idle();
    @(negedge clk);
    check_regs("R10", "R10");
    chk("R10", "done idle", 32'(done_o), 32'd0);
    chk("R10", "err idle", 32'(err_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    model_reset();
    do_reset();

    // directed: interrupt, fast miss, double miss, nested trap and break
    issue(3'd0, 5'd1, 32'h0000_1000, 32'h0);
    issue(3'd1, 5'd9, 32'h0000_2000, 32'hDEAD_0000);
    idle();
    issue(3'd1, 5'd9, 32'h0000_3000, 32'h0);
    issue(3'd4, 5'd3, 32'h0000_4000, 32'h0);
    issue(3'd5, 5'd5, 32'h0000_5000, 32'h0);
    issue(3'd2, 5'd14, 32'h0000_6000, 32'h0);
    issue(3'd7, 5'd31, 32'h0000_7000, 32'h1234_5678);
    idle();
    issue(3'd6, 5'd31, 32'h0000_8000, 32'hCAFE_0003);
    issue(3'd0, 5'd2, 32'hFFFF_FFFC, 32'h0);

    do_reset();
    issue(3'd5, 5'd7, 32'h0000_0A00, 32'h0);
    issue(3'd5, 5'd7, 32'h0000_0B00, 32'h0);
    do_reset();
    issue(3'd3, 5'd11, 32'h0000_0C00, 32'h0);
    issue(3'd3, 5'd11, 32'h0000_0D00, 32'h0);
    issue(3'd1, 5'd12, 32'h0000_0E00, 32'h0);

    // random sequences with occasional reset
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 31);
      if (r == 0) do_reset();
      else if (r < 4) idle();
      else issue(3'($urandom_range(0, 7)), 5'($urandom), $urandom, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule